// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block packs a stream of decoded instructions into dispatch groups of five slots, numbered 0 to 4. Each instruction arrives on a valid/ready interface with a 4-bit class code. The allocator decides which slot or slots the instruction takes and whether the current group must close. For a memory operation it also reports which of the two load/store units the slot position selects.

Slots fill strictly in program order. Slots 0 to 3 take ordinary work, and slot 4 is reserved for a branch. Some classes are pinned to the front of a group or take all four ordinary slots. When an instruction cannot fit behind the work already placed, the allocator closes the group, stalls the stream for one cycle and starts a new group with that instruction. A closed group is reported as a one-cycle emit pulse that carries the mask of occupied slots. A flush input throws away a partly built group without emitting it.

Top module: `dga_slot_alloc`

## Requirements
- R1: A group has five slots. When a group closes, `grp_emit_o` pulses high for one cycle on the next clock. In that cycle `grp_slots_o` bit i is 1 exactly when slot i holds an instruction. When no group is emitted, `grp_slots_o` is zero.
- R2: Placement is in order. An accepted instruction's first slot (`acc_slot_o`) is the lowest slot above every slot used earlier in the group, and slots skipped over stay empty. Single ops (code 0) and memory ops (code 1) take one slot in 0..3. Codes 8 to 15 behave as single ops.
- R3: A branch (code 7) always takes slot 4 and is always accepted. Any earlier slots still empty stay empty, and the group closes, so it is emitted on the next clock.
- R4: A memory op reports `mem_vld_o`=1 when it is accepted. `lsu_sel_o` is 0 (first unit) for slot 0 or 3 and 1 (second unit) for slot 1 or 2. `mem_vld_o` is 0 for every other accepted class.
- R5: A two-op instruction (code 2) takes two consecutive slots, and a three-op instruction (code 3) takes three, all within slots 0..3. A wrapped placement such as slots 3 and 0 would put a later op below an earlier one, so it is never used; the group closes instead.
- R6: A first-pair op (code 4) takes slots 0 and 1 and counts as a memory op. A first-slot op (code 6) takes slot 0 only. A whole-group op (code 5) takes slots 0 to 3 and closes its group at once. All three classes can only start an empty group.
- R7: If an instruction does not fit in the current group, `in_ready_o` is 0 for that cycle and the current group is emitted. On the next cycle the instruction is accepted at the start of a new group.
- R8: While `flush_i` is 1, `in_ready_o` is 0. The partial group is discarded, no emit follows, and the next instruction starts at slot 0.
- R9: After reset, the group is empty, `grp_emit_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard the partly built group |
| in_valid_i | input | 1 | Instruction present |
| in_class_i | input | 4 | Operation class code |
| in_ready_o | output | 1 | Instruction accepted this cycle when valid |
| acc_slot_o | output | 3 | First slot of the accepted instruction |
| mem_vld_o | output | 1 | Accepted instruction is a memory op |
| lsu_sel_o | output | 1 | Load/store unit chosen by the slot position |
| grp_emit_o | output | 1 | One-cycle pulse: a group has closed |
| grp_slots_o | output | 5 | Occupied-slot mask of the emitted group |

## Verification
The checker tests several rules on every cycle:
- an accepted branch sits in slot 4, and a first-slot op sits in slot 0;
- each memory op is steered by its slot;
- a stall with no flush is always followed by an emit;
- a whole-group op produces a four-slot emit;
- no emit follows a flush.

The in-order packing, the consecutive pairs and triples, and the exact emitted masks depend on the history of the group. Only the bench's scoreboard shows these. It models the group state from the requirements and compares every emitted mask in the order the groups close.

// File: rtl/dga_pkg.sv
package dga_pkg;
  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_SINGLE = 4'd0,
    CL_MEM    = 4'd1,
    CL_TWO    = 4'd2,
    CL_THREE  = 4'd3,
    CL_FPAIR  = 4'd4,
    CL_WHOLE  = 4'd5,
    CL_FSLOT  = 4'd6,
    CL_BRANCH = 4'd7
  } op_class_e;
endpackage

// File: rtl/dga_place.sv
// Combinational placement: fit test, slot bits and pointer advance.
module dga_place import dga_pkg::*; #(
  parameter int NSLOT = 5,
  parameter int PW    = $clog2(NSLOT)
) (
  input  logic [PW-1:0]    ptr_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             fit_o,
  output logic [PW-1:0]    start_o,
  output logic [NSLOT-1:0] bits_o,
  output logic [PW-1:0]    nptr_o,
  output logic             close_o,
  output logic             is_mem_o
);
  localparam int LAST = NSLOT - 1;

  logic [PW:0] width;
  logic [PW:0] span_end;
  logic        anchored;
  logic        is_br;
  logic        is_whole;

  always_comb begin
    width    = (PW+1)'(1);
    anchored = 1'b0;
    is_br    = 1'b0;
    is_whole = 1'b0;
    is_mem_o = 1'b0;
    case (cls_i)
      CL_MEM:    is_mem_o = 1'b1;
      CL_TWO:    width = (PW+1)'(2);
      CL_THREE:  width = (PW+1)'(3);
      CL_FPAIR:  begin width = (PW+1)'(2); anchored = 1'b1; is_mem_o = 1'b1; end
      CL_WHOLE:  begin width = (PW+1)'(LAST); anchored = 1'b1; is_whole = 1'b1; end
      CL_FSLOT:  anchored = 1'b1;
      CL_BRANCH: is_br = 1'b1;
      default:   width = (PW+1)'(1);
    endcase
  end

  assign span_end = {1'b0, ptr_i} + width;

  always_comb begin
    if (is_br) begin
      fit_o   = 1'b1;
      start_o = PW'(LAST);
      nptr_o  = '0;
      close_o = 1'b1;
    end else begin
      fit_o   = anchored ? (ptr_i == '0) : (span_end <= (PW+1)'(LAST));
      start_o = ptr_i;
      nptr_o  = span_end[PW-1:0];
      close_o = is_whole;
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (is_br)
        bits_o[i] = (i == LAST);
      else
        bits_o[i] = ((PW+1)'(i) >= {1'b0, ptr_i}) && ((PW+1)'(i) < span_end);
    end
  end
endmodule

// File: rtl/dga_lsu_steer.sv
// Slot position decides the load/store unit.
module dga_lsu_steer #(
  parameter int NSLOT = 5,
  parameter int PW    = $clog2(NSLOT)
) (
  input  logic          accept_i,
  input  logic          is_mem_i,
  input  logic [PW-1:0] slot_i,
  output logic          mem_vld_o,
  output logic          sel_o
);
  assign mem_vld_o = accept_i & is_mem_i;
  assign sel_o     = (slot_i == PW'(1)) || (slot_i == PW'(2));
endmodule

// File: rtl/dga_group.sv
// Group occupancy, fill pointer and emit register.
module dga_group #(
  parameter int NSLOT = 5,
  parameter int PW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_i,
  input  logic             accept_i,
  input  logic             fit_i,
  input  logic             close_i,
  input  logic [NSLOT-1:0] bits_i,
  input  logic [PW-1:0]    nptr_i,
  output logic [PW-1:0]    ptr_o,
  output logic             emit_o,
  output logic [NSLOT-1:0] mask_o
);
  logic [NSLOT-1:0] occ_q, occ_d;
  logic [PW-1:0]    ptr_q, ptr_d;
  logic             emit_d;
  logic [NSLOT-1:0] mask_d;
  logic             state_en;

  assign state_en = flush_i | accept_i | (req_i & ~fit_i);

  always_comb begin
    occ_d  = occ_q;
    ptr_d  = ptr_q;
    emit_d = 1'b0;
    mask_d = '0;
    if (flush_i) begin
      occ_d = '0;
      ptr_d = '0;
    end else if (accept_i && close_i) begin
      emit_d = 1'b1;
      mask_d = occ_q | bits_i;
      occ_d  = '0;
      ptr_d  = '0;
    end else if (accept_i) begin
      occ_d = occ_q | bits_i;
      ptr_d = nptr_i;
    end else if (req_i && !fit_i) begin
      emit_d = 1'b1;
      mask_d = occ_q;
      occ_d  = '0;
      ptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      ptr_q  <= '0;
      emit_o <= 1'b0;
      mask_o <= '0;
    end else begin
      if (state_en) begin
        occ_q <= occ_d;
        ptr_q <= ptr_d;
      end
      emit_o <= emit_d;
      mask_o <= mask_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dga_slot_alloc.sv
module dga_slot_alloc import dga_pkg::*; #(
  parameter  int NSLOT = 5,
  localparam int PW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             in_valid_i,
  input  logic [CLS_W-1:0] in_class_i,
  output logic             in_ready_o,
  output logic [PW-1:0]    acc_slot_o,
  output logic             mem_vld_o,
  output logic             lsu_sel_o,
  output logic             grp_emit_o,
  output logic [NSLOT-1:0] grp_slots_o
);
  logic [PW-1:0]    ptr;
  logic             fit;
  logic [PW-1:0]    start;
  logic [NSLOT-1:0] bits;
  logic [PW-1:0]    nptr;
  logic             close_now;
  logic             is_mem;
  logic             accept;

  dga_place #(.NSLOT(NSLOT), .PW(PW)) place_i (
    .ptr_i(ptr), .cls_i(in_class_i), .fit_o(fit), .start_o(start),
    .bits_o(bits), .nptr_o(nptr), .close_o(close_now), .is_mem_o(is_mem)
  );

  assign in_ready_o = ~flush_i & fit;
  assign accept     = in_valid_i & in_ready_o;
  assign acc_slot_o = start;

  dga_lsu_steer #(.NSLOT(NSLOT), .PW(PW)) steer_i (
    .accept_i(accept), .is_mem_i(is_mem), .slot_i(start),
    .mem_vld_o(mem_vld_o), .sel_o(lsu_sel_o)
  );

  dga_group #(.NSLOT(NSLOT), .PW(PW)) group_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .req_i(in_valid_i),
    .accept_i(accept), .fit_i(fit), .close_i(close_now), .bits_i(bits),
    .nptr_i(nptr), .ptr_o(ptr), .emit_o(grp_emit_o), .mask_o(grp_slots_o)
  );
endmodule

// File: rtl/dga_chk.sv
module dga_chk #(
  parameter  int NSLOT = 5,
  localparam int PW    = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             in_valid_i,
  input logic [3:0]       in_class_i,
  input logic             in_ready_o,
  input logic [PW-1:0]    acc_slot_o,
  input logic             mem_vld_o,
  input logic             lsu_sel_o,
  input logic             grp_emit_o,
  input logic [NSLOT-1:0] grp_slots_o
);
  localparam int LAST = NSLOT - 1;
  localparam logic [NSLOT-1:0] LOW_ALL = NSLOT'((1 << LAST) - 1);

  logic acc;
  assign acc = in_valid_i && in_ready_o;

  // R3
  branch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class_i == 4'd7) |-> (acc_slot_o == PW'(LAST)));

  // R4
  lsu_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld_o |-> (lsu_sel_o == (acc_slot_o == PW'(1) || acc_slot_o == PW'(2))));

  // R7
  stall_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !in_ready_o && !flush_i) |=> grp_emit_o);

  // R6
  whole_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class_i == 4'd5) |=> (grp_emit_o && grp_slots_o == LOW_ALL));

  // R6
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_class_i == 4'd6) |-> (acc_slot_o == '0));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !grp_emit_o);

  // R1
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_emit_o |-> (grp_slots_o == '0));
endmodule

bind dga_slot_alloc dga_chk #(.NSLOT(NSLOT)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
  .in_class_i(in_class_i), .in_ready_o(in_ready_o), .acc_slot_o(acc_slot_o),
  .mem_vld_o(mem_vld_o), .lsu_sel_o(lsu_sel_o), .grp_emit_o(grp_emit_o),
  .grp_slots_o(grp_slots_o)
);

// File: tb/dga_slot_alloc_tb_top.sv
`timescale 1ns/1ps
module dga_slot_alloc_tb_top;
  localparam logic [3:0] K_SGL = 4'd0, K_MEM = 4'd1, K_TWO = 4'd2, K_THR = 4'd3,
                         K_FPR = 4'd4, K_WHL = 4'd5, K_FSL = 4'd6, K_BR = 4'd7;

  logic clk = 1'b0;
  logic rst_n;
  logic flush_i;
  logic in_valid_i;
  logic [3:0] in_class_i;
  logic in_ready_o;
  logic [2:0] acc_slot_o;
  logic mem_vld_o;
  logic lsu_sel_o;
  logic grp_emit_o;
  logic [4:0] grp_slots_o;

  always #4 clk = ~clk;

  dga_slot_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
    .in_class_i(in_class_i), .in_ready_o(in_ready_o), .acc_slot_o(acc_slot_o),
    .mem_vld_o(mem_vld_o), .lsu_sel_o(lsu_sel_o), .grp_emit_o(grp_emit_o),
    .grp_slots_o(grp_slots_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [4:0] exp_q[$];
  int   mptr;
  logic [4:0] mocc;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model of fit from the requirements
  function automatic bit mfit(input logic [3:0] c, input int p);
    case (c)
      K_TWO:   return p <= 2;
      K_THR:   return p <= 1;
      K_FPR, K_WHL, K_FSL: return p == 0;
      K_BR:    return 1;
      default: return p <= 3;
    endcase
  endfunction

  function automatic int mwidth(input logic [3:0] c);
    case (c)
      K_TWO, K_FPR: return 2;
      K_THR:        return 3;
      K_WHL:        return 4;
      default:      return 1;
    endcase
  endfunction

  task automatic send(input logic [3:0] c, input string req);
    bit f;
    int st;
    bit mem;
    f = mfit(c, mptr);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_class_i = c;
    #1;
    chk(in_ready_o == f, f ? req : "R7", "ready", in_ready_o, f);
    if (!f) begin
      exp_q.push_back(mocc);
      mocc = '0;
      mptr = 0;
      @(negedge clk);
      #1;
      chk(in_ready_o == 1'b1, "R7", "ready after close", in_ready_o, 1);
    end
    st = (c == K_BR) ? 4 : mptr;
    chk(acc_slot_o == 3'(st), req, "slot", acc_slot_o, st);
    mem = (c == K_MEM) || (c == K_FPR);
    chk(mem_vld_o == mem, "R4", "mem_vld", mem_vld_o, mem);
    if (mem)
      chk(lsu_sel_o == (st == 1 || st == 2), "R4", "lsu_sel", lsu_sel_o, (st == 1 || st == 2));
    if (c == K_BR) begin
      exp_q.push_back(mocc | 5'b10000);
      mocc = '0;
      mptr = 0;
    end else begin
      for (int i = mptr; i < mptr + mwidth(c); i++) mocc[i] = 1'b1;
      mptr = mptr + mwidth(c);
      if (c == K_WHL) begin
        exp_q.push_back(mocc);
        mocc = '0;
        mptr = 0;
      end
    end
    @(posedge clk);
    #1;
    in_valid_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    in_valid_i = 1'b1;
    in_class_i = K_SGL;
    #1;
    chk(in_ready_o == 1'b0, "R8", "ready during flush", in_ready_o, 0);
    @(negedge clk);
    flush_i = 1'b0;
    in_valid_i = 1'b0;
    mocc = '0;
    mptr = 0;
  endtask

  // Monitor: pop expected masks as groups are emitted
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && grp_emit_o === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected emit mask", grp_slots_o, 0);
        end else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          chk(grp_slots_o == e, "R1", "emit mask", grp_slots_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    flush_i = 1'b0;
    in_valid_i = 1'b0;
    in_class_i = '0;
    mptr = 0;
    mocc = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R9", "ready after reset", in_ready_o, 1);
    chk(grp_emit_o == 1'b0, "R9", "emit after reset", grp_emit_o, 0);
    chk(grp_slots_o == 5'b0, "R9", "mask after reset", grp_slots_o, 0);

    // Full group with memory steering, closed by a branch
    send(K_SGL, "R2"); send(K_SGL, "R2"); send(K_MEM, "R4"); send(K_MEM, "R4");
    send(K_BR, "R3");
    // Memory in slots 0/1, pair at 2-3, then a single that no longer fits
    send(K_MEM, "R4"); send(K_MEM, "R4"); send(K_TWO, "R5"); send(K_SGL, "R7");
    // Triple at 1-3, then branch
    send(K_THR, "R5"); send(K_BR, "R3");
    // First-pair ops and a triple that must start over
    send(K_FPR, "R6"); send(K_FPR, "R6"); send(K_TWO, "R5"); send(K_THR, "R5");
    send(K_SGL, "R2"); send(K_BR, "R3");
    // Pair at slot 3 would wrap, so the group closes
    send(K_SGL, "R2"); send(K_SGL, "R2"); send(K_SGL, "R2"); send(K_TWO, "R5");
    send(K_BR, "R3");
    // Whole-group ops
    send(K_WHL, "R6"); send(K_SGL, "R2"); send(K_WHL, "R6");
    // First-slot op
    send(K_FSL, "R6"); send(K_FSL, "R6"); send(K_BR, "R3");
    // Branch alone leaves slots 0..3 empty
    send(K_BR, "R3");
    // Flush discards a partial group
    send(K_SGL, "R8"); send(K_SGL, "R8"); do_flush(); send(K_MEM, "R8"); send(K_BR, "R3");
    // Unknown class codes act as singles
    send(4'hF, "R2"); send(4'h9, "R2"); send(K_BR, "R3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "groups left unemitted", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule